// File: doc/BRIEF.md
# SKP-Adjusting Receive Elastic Buffer

This block is the clock-compensation stage on the receive side of an 8b/10b serial link. Decoded symbols (a byte plus a control flag) arrive in the recovered-clock domain and leave in the local-clock domain. The two clocks may differ by a few hundred ppm, so the buffer slowly fills or drains. The only correction it ever makes is to change the length of skip ordered sets. Each such set is a comma control symbol followed by skip control symbols. Data and all other symbols pass through unchanged and in order.

On the write side, a skip symbol inside an ordered set is discarded when the write-side fill is above a high mark. On the read side, a skip symbol inside an ordered set is emitted twice when the read-side fill is below a low mark. Each ordered set is shortened or lengthened by at most one symbol. The pointers cross between the domains as Gray codes through a synchronizer chain. Sticky flags report a write into a full buffer and a read from an empty one. A fill count is available in the read domain.

Top module: `skp_elastic_buf`

## Requirements
- R1: After reset, rd_valid, overflow and underflow are 0 and rd_fill is 0.
- R2: Every symbol that is not a skip symbol is delivered on the read side exactly once, in write order, with its byte and K flag unchanged, while no overflow occurs.
- R3: The comma is byte BCh with K=1 and the skip is byte 1Ch with K=1. An ordered set starts at a comma and covers the skip symbols that follow it up to the next other symbol. Skip symbols outside a set, and bytes BCh or 1Ch with K=0, are never added or removed.
- R4: A skip symbol inside a set is not stored when it is written while the write-side fill exceeds HI_MARK. At most one is removed per set, and the comma is always stored.
- R5: When a skip symbol inside a set is read while the read-side fill is below LO_MARK, it is emitted twice. At most one is added per set, so a set of three skips leaves with at most four.
- R6: A write while the buffer holds 2^ADDR_W entries is discarded and sets overflow. Overflow stays 1 until wr_rst_n.
- R7: rd_en while the buffer is empty produces no rd_valid and sets underflow. Underflow stays 1 until rd_rst_n.
- R8: rd_valid is 1 only in the cycle after a cycle with rd_en, and it carries the symbol read then.
- R9: rd_fill equals the number of stored, unread entries once the write-side pointer has settled through the synchronizer (SYNC_STAGES read cycles plus one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_valid | input | 1 | A symbol is presented this cycle |
| wr_byte | input | 8 | Decoded symbol byte |
| wr_k | input | 1 | Symbol is a control character |
| overflow | output | 1 | Sticky: a write was lost to a full buffer |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Request one symbol |
| rd_valid | output | 1 | rd_byte/rd_k hold a symbol |
| rd_byte | output | 8 | Output symbol byte |
| rd_k | output | 1 | Output control flag |
| underflow | output | 1 | Sticky: a read hit an empty buffer |
| rd_fill | output | ADDR_W+1 | Read-domain fill count |

## Verification
The in-line properties assume that both domains leave reset together and that each pointer moves by at most one entry per clock of its own domain. Under these conditions the fill seen in either domain can never exceed the depth. The bench resets both domains at once before every scenario. It sets the fill level by pausing and resuming reads, so drop and insert decisions happen at known fill values. While a decision is pending, writes only happen when the read side is stopped or slower, so the fill values seen in the two domains cannot go out of step.

// File: rtl/eb_pkg.sv
package eb_pkg;
   localparam int unsigned SYM_BYTE_W = 8;
   localparam logic [SYM_BYTE_W-1:0] COMMA_BYTE = 8'hBC;
   localparam logic [SYM_BYTE_W-1:0] SKIP_BYTE  = 8'h1C;

   typedef struct packed {
      logic                  is_k;
      logic [SYM_BYTE_W-1:0] val;
   } sym_t;

   function automatic logic sym_is_comma(input sym_t s);
      return s.is_k && (s.val == COMMA_BYTE);
   endfunction

   function automatic logic sym_is_skip(input sym_t s);
      return s.is_k && (s.val == SKIP_BYTE);
   endfunction
endpackage

// File: rtl/eb_gray_sync.sv
module eb_gray_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] gray_out
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= gray_in;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign gray_out = stg[STAGES-1];
endmodule

// File: rtl/eb_mem.sv
module eb_mem
   import eb_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  sym_t              wdata,
   input  logic [ADDR_W-1:0] raddr,
   output sym_t              rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   sym_t cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/eb_wr_ctl.sv
module eb_wr_ctl
   import eb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned HI_MARK = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  sym_t              in_sym,
   input  logic [ADDR_W:0]   rptr_gray_s,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output sym_t              mem_wdata,
   output logic [ADDR_W:0]   wptr_gray,
   output logic              overflow
);
   localparam int unsigned PW    = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] HI_L   = PW'(HI_MARK);
   localparam logic [PW-1:0] FULL_L = PW'(DEPTH);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wbin, wbin_nxt, rbin_s, fill;
   logic          in_set, drop_done;
   logic          is_comma, is_skip, full, drop, push;

   assign rbin_s   = g2b(rptr_gray_s);
   assign fill     = wbin - rbin_s;
   assign full     = (fill == FULL_L);
   assign is_comma = sym_is_comma(in_sym);
   assign is_skip  = sym_is_skip(in_sym);
   assign drop     = in_valid && is_skip && in_set && !drop_done && (fill > HI_L);
   assign push     = in_valid && !drop && !full;
   assign wbin_nxt = wbin + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin      <= '0;
         wptr_gray <= '0;
         in_set    <= 1'b0;
         drop_done <= 1'b0;
         overflow  <= 1'b0;
      end else begin
         if (push) begin
            wbin      <= wbin_nxt;
            wptr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
         end
         if (in_valid) begin
            if (is_comma) begin
               in_set    <= 1'b1;
               drop_done <= 1'b0;
            end else if (!is_skip) begin
               in_set <= 1'b0;
            end
         end
         if (drop) drop_done <= 1'b1;
         if (in_valid && !drop && full) overflow <= 1'b1;
      end
   end

   assign mem_we    = push;
   assign mem_waddr = wbin[ADDR_W-1:0];
   assign mem_wdata = in_sym;

   AST_WR_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_L); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R6
   AST_COMMA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_comma && !full) |=> (wbin == $past(wbin) + PW'(1))); // R4
endmodule

// File: rtl/eb_rd_ctl.sv
module eb_rd_ctl
   import eb_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned LO_MARK = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wptr_gray_s,
   input  sym_t              mem_rdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [ADDR_W:0]   rptr_gray,
   output logic              out_valid,
   output sym_t              out_sym,
   output logic              underflow,
   output logic [ADDR_W:0]   fill
);
   localparam int unsigned PW    = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] LO_L   = PW'(LO_MARK);
   localparam logic [PW-1:0] FULL_L = PW'(DEPTH);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] rbin, rbin_nxt, wbin_s;
   logic          in_set, ins_done;
   logic          empty, head_comma, head_skip, ins, pop;

   assign wbin_s     = g2b(wptr_gray_s);
   assign fill       = wbin_s - rbin;
   assign empty      = (fill == '0);
   assign head_comma = sym_is_comma(mem_rdata);
   assign head_skip  = sym_is_skip(mem_rdata);
   assign ins        = rd_en && !empty && head_skip && in_set && !ins_done && (fill < LO_L);
   assign pop        = rd_en && !empty && !ins;
   assign rbin_nxt   = rbin + PW'(1);
   assign mem_raddr  = rbin[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin      <= '0;
         rptr_gray <= '0;
         in_set    <= 1'b0;
         ins_done  <= 1'b0;
         underflow <= 1'b0;
         out_valid <= 1'b0;
         out_sym   <= '0;
      end else begin
         out_valid <= rd_en && !empty;
         if (rd_en && !empty) out_sym <= mem_rdata;
         if (pop) begin
            rbin      <= rbin_nxt;
            rptr_gray <= rbin_nxt ^ (rbin_nxt >> 1);
         end
         if (rd_en && !empty) begin
            if (head_comma) begin
               in_set   <= 1'b1;
               ins_done <= 1'b0;
            end else if (!head_skip) begin
               in_set <= 1'b0;
            end
         end
         if (ins) ins_done <= 1'b1;
         if (rd_en && empty) underflow <= 1'b1;
      end
   end

   AST_RD_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_L); // R9
   AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow); // R7
   AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(rd_en)); // R8
   AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> (!out_valid && underflow)); // R7
endmodule

// File: rtl/skp_elastic_buf.sv
module skp_elastic_buf
   import eb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LO_MARK     = (1 << ADDR_W) / 2 - 2,
   parameter int unsigned HI_MARK     = (1 << ADDR_W) / 2 + 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_valid,
   input  logic [7:0]        wr_byte,
   input  logic              wr_k,
   output logic              overflow,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [7:0]        rd_byte,
   output logic              rd_k,
   output logic              underflow,
   output logic [ADDR_W:0]   rd_fill
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PW    = ADDR_W + 1;

   if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
      $error("skp_elastic_buf: ADDR_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("skp_elastic_buf: SYNC_STAGES must be at least 2");
   end
   if (LO_MARK >= HI_MARK || HI_MARK >= DEPTH) begin : g_bad_marks
      $error("skp_elastic_buf: need LO_MARK < HI_MARK < depth");
   end

   sym_t              w_sym, m_wdata, m_rdata, r_sym;
   logic              m_we;
   logic [ADDR_W-1:0] m_waddr, m_raddr;
   logic [PW-1:0]     wgray, wgray_s, rgray, rgray_s;

   assign w_sym = '{is_k: wr_k, val: wr_byte};

   eb_wr_ctl #(.ADDR_W(ADDR_W), .HI_MARK(HI_MARK)) wr_ctl_i (
      .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(wr_valid), .in_sym(w_sym),
      .rptr_gray_s(rgray_s), .mem_we(m_we), .mem_waddr(m_waddr),
      .mem_wdata(m_wdata), .wptr_gray(wgray), .overflow(overflow));

   eb_mem #(.ADDR_W(ADDR_W)) mem_i (
      .wclk(wr_clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
      .raddr(m_raddr), .rdata(m_rdata));

   eb_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) w2r_i (
      .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray), .gray_out(wgray_s));

   eb_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) r2w_i (
      .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rgray), .gray_out(rgray_s));

   eb_rd_ctl #(.ADDR_W(ADDR_W), .LO_MARK(LO_MARK)) rd_ctl_i (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wptr_gray_s(wgray_s),
      .mem_rdata(m_rdata), .mem_raddr(m_raddr), .rptr_gray(rgray),
      .out_valid(rd_valid), .out_sym(r_sym), .underflow(underflow),
      .fill(rd_fill));

   assign rd_byte = r_sym.val;
   assign rd_k    = r_sym.is_k;
endmodule

// File: tb/skp_elastic_buf_tb_top.sv
module skp_elastic_buf_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = CLK_PERIOD + 2;
   localparam int AW         = 4;

   logic wr_clk = 0, rd_clk = 0;
   logic wr_rst_n = 0, rd_rst_n = 0;
   logic wr_valid = 0, wr_k = 0, rd_en = 0;
   logic [7:0] wr_byte = 0;
   logic overflow, rd_valid, rd_k, underflow;
   logic [7:0] rd_byte;
   logic [AW:0] rd_fill;

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2) rd_clk = ~rd_clk;

   skp_elastic_buf #(.ADDR_W(AW), .SYNC_STAGES(2), .LO_MARK(2), .HI_MARK(10)) dut_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
      .wr_k(wr_k), .overflow(overflow), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
      .rd_en(rd_en), .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_k(rd_k),
      .underflow(underflow), .rd_fill(rd_fill));

   int tests = 0, fails = 0;
   logic [8:0] exp_q [$];
   int skp_run = 0, last_run = 0, out_cnt = 0, data_cnt = 0;
   bit rd_go = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // read request driver
   initial forever begin
      @(posedge rd_clk);
      #1 rd_en = rd_go;
   end

   // monitor / scoreboard
   always @(negedge rd_clk) begin
      if (rd_rst_n && rd_valid) begin
         out_cnt++;
         if (rd_k && rd_byte == 8'h1C) begin
            skp_run++;
         end else begin
            if (skp_run > 0) chk(skp_run <= 4, "R5 skip run too long", skp_run, 4);
            last_run = skp_run;
            skp_run  = 0;
            data_cnt++;
            if (exp_q.size() == 0) begin
               chk(0, "R2 unexpected symbol", {23'd0, rd_k, rd_byte}, -1);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk({rd_k, rd_byte} == e, "R2 symbol order", {23'd0, rd_k, rd_byte}, {23'd0, e});
            end
         end
      end
   end

   task automatic put(input logic [7:0] b, input logic k, input bit expect_it);
      @(posedge wr_clk);
      #1;
      wr_valid = 1; wr_byte = b; wr_k = k;
      if (expect_it && !(k && b == 8'h1C)) exp_q.push_back({k, b});
   endtask

   task automatic idle();
      @(posedge wr_clk);
      #1 wr_valid = 0;
   endtask

   task automatic put_set();
      put(8'hBC, 1, 1);
      for (int i = 0; i < 3; i++) put(8'h1C, 1, 1);
   endtask

   task automatic rd_wait(input int n);
      repeat (n) @(posedge rd_clk);
   endtask

   task automatic do_reset();
      wr_rst_n = 0; rd_rst_n = 0; rd_go = 0; wr_valid = 0;
      rd_wait(4);
      exp_q.delete();
      skp_run = 0; last_run = 0; out_cnt = 0; data_cnt = 0;
      @(negedge wr_clk) wr_rst_n = 1;
      @(negedge rd_clk) rd_rst_n = 1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         chk(0, "watchdog expired", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      @(negedge rd_clk);
      chk(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
      chk(overflow == 0, "R1 overflow", overflow, 0);
      chk(underflow == 0, "R1 underflow", underflow, 0);
      chk(rd_fill == 0, "R1 rd_fill", rd_fill, 0);

      // R7 read from empty
      rd_go = 1; rd_wait(5); rd_go = 0; rd_wait(3);
      @(negedge rd_clk);
      chk(underflow == 1, "R7 underflow set", underflow, 1);
      chk(out_cnt == 0, "R7 no output from empty", out_cnt, 0);

      // R9 fill readout, then R4 drop at high fill
      do_reset();
      for (int i = 0; i < 7; i++) put(8'h10 + 8'(i), 0, 1);
      idle(); rd_wait(6);
      @(negedge rd_clk);
      chk(rd_fill == 7, "R9 fill after 7 writes", rd_fill, 7);
      for (int i = 7; i < 12; i++) put(8'h10 + 8'(i), 0, 1);
      put_set();
      put(8'hA5, 0, 1);
      idle(); rd_wait(6);
      @(negedge rd_clk);
      chk(rd_fill == 16, "R4 one skip removed at high fill", rd_fill, 16);
      chk(overflow == 0, "R6 no overflow at exact depth", overflow, 0);
      rd_go = 1; rd_wait(30); rd_go = 0;
      chk(last_run == 2, "R4 skip run after drop", last_run, 2);
      chk(exp_q.size() == 0, "R4 comma and data all delivered", exp_q.size(), 0);
      chk(data_cnt == 14, "R2 delivered count", data_cnt, 14);

      // R5 insert at low fill
      do_reset();
      put_set(); idle(); rd_wait(6);
      rd_go = 1; rd_wait(15); rd_go = 0; rd_wait(3);
      put(8'h5A, 0, 1); idle(); rd_wait(6);
      rd_go = 1; rd_wait(10); rd_go = 0;
      chk(last_run == 4, "R5 skip run after insert", last_run, 4);
      chk(exp_q.size() == 0, "R5 all delivered", exp_q.size(), 0);

      // R3 lone skips and K=0 look-alikes are untouched
      do_reset();
      for (int i = 0; i < 11; i++) put(8'h40 + 8'(i), 0, 1);
      put(8'h1C, 0, 1);
      put(8'hBC, 0, 1);
      put(8'h1C, 1, 1);
      put(8'h1C, 1, 1);
      put(8'h77, 0, 1);
      idle(); rd_wait(6);
      @(negedge rd_clk);
      chk(rd_fill == 16, "R3 nothing removed outside a set", rd_fill, 16);
      rd_go = 1; rd_wait(30); rd_go = 0;
      chk(last_run == 2, "R3 lone skip run kept", last_run, 2);
      chk(exp_q.size() == 0, "R3 all delivered", exp_q.size(), 0);

      // R6 overflow
      do_reset();
      for (int i = 0; i < 18; i++) put(8'h80 + 8'(i), 0, i < 16);
      idle(); rd_wait(6);
      @(negedge rd_clk);
      chk(overflow == 1, "R6 overflow set", overflow, 1);
      chk(rd_fill == 16, "R6 fill capped at depth", rd_fill, 16);
      rd_go = 1; rd_wait(30); rd_go = 0;
      chk(exp_q.size() == 0, "R6 extra writes discarded", exp_q.size(), 0);
      chk(data_cnt == 16, "R6 delivered count", data_cnt, 16);
      chk(overflow == 1, "R6 overflow sticky", overflow, 1);

      // R2 / R8 streaming with sets, reads running
      do_reset();
      rd_go = 1;
      for (int i = 0; i < 60; i++) begin
         put(8'(i), 0, 1); idle();
         if (i % 10 == 5) begin
            put_set(); idle();
         end
      end
      rd_wait(60); rd_go = 0;
      chk(exp_q.size() == 0, "R2 stream all delivered", exp_q.size(), 0);
      chk(data_cnt == 66, "R8 stream delivered count", data_cnt, 66);
      chk(overflow == 0, "R6 no overflow in stream", overflow, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule